// File: doc/BRIEF.md
# Floating-Point Register Bank Move Unit

This unit holds a floating-point register file of two banks, each with sixteen 32-bit words, and executes the data-movement subset of a floating-point instruction set. It performs register-to-register copies, loads and stores, and it toggles two mode bits. One bank is the foreground bank. The other is the background bank. A bank-select bit decides which physical bank is in the foreground. A size bit makes every move transfer either a single 32-bit word or an even/odd pair that forms one 64-bit value.

The surrounding pipeline does the decoding of the integer operands. It presents a 16-bit move opcode together with the current values of R0, the integer register named by the source field (Rm) and the integer register named by the destination field (Rn). Register copies and mode toggles complete on the cycle the opcode is accepted. A load or store raises a single memory request and holds it until the memory accepts it. Load data and any base-register update are committed on the cycle of acceptance. The updated base value is returned to the integer file through a strobe and an index.

Top module: `fpmov_unit`

## Requirements
- R1: A synchronous reset clears all 32 physical registers, the bank-select bit and the size bit to zero. After reset there is no memory request and `op_ready` is high.
- R2: With size 0, opcode `1111 nnnn mmmm 1100` copies foreground register m to foreground register n. All other registers are left unchanged.
- R3: With size 1, the move copies a pair. The source pair index is m>>1 and m[0] picks the foreground (0) or background (1) bank. The destination pair index is n>>1 and n[0] picks the bank in the same way. All four bank routes work, and both words of the pair move together.
- R4: Opcode 0xFBFD inverts `bank_sel`. Physical bank `bank_sel` is the foreground bank (it is bit 4 of `dbg_addr`), and physical bank `~bank_sel` is the background bank.
- R5: Opcode 0xFBFD does not change `size_sel`, and opcode 0xF3FD inverts `size_sel` without changing `bank_sel`.
- R6: The low nibble of a `1111`-prefixed opcode selects the access. 8 is a load from [Rm]. 6 is a load from [R0+Rm]. 9 is a load from [Rm] with post-increment. A is a store to [Rn]. 7 is a store to [R0+Rn]. B is a store with pre-decrement, and its address is Rn minus the step. A load writes field n and a store reads field m. `mem_we` is 1 only for stores.
- R7: Only the post-increment and pre-decrement forms pulse `base_wb_valid`. The step is 4 with size 0 and 8 with size 1. The new base is Rm+step for the load (index m) and Rn−step for the store (index n). The other access forms never pulse the strobe.
- R8: A 64-bit transfer places the even register of the pair in bits 63:32 and the odd register in bits 31:0. A 32-bit transfer uses bits 31:0, and a 32-bit store drives bits 63:32 to zero.
- R9: A request keeps `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ready`. Register loads and the base strobe take effect only on the cycle with `mem_valid && mem_ready`. `op_ready` is low while a request is outstanding.
- R10: An opcode whose top nibble is not 1111, or whose low nibble is not a move form listed here (other than the two toggle encodings), is accepted without effect. It raises no request, writes no register and changes no mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode present |
| op_ready | output | 1 | Unit idle, opcode accepted when valid |
| op_code | input | 16 | Move opcode |
| r0_val | input | ADDR_W | Value of integer R0 |
| rm_val | input | ADDR_W | Value of the integer register named by bits 7:4 |
| rn_val | input | ADDR_W | Value of the integer register named by bits 11:8 |
| mem_valid | output | 1 | Memory request outstanding |
| mem_ready | input | 1 | Memory accepts the request; read data valid this cycle |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 2*REG_W | Store data |
| mem_rdata | input | 2*REG_W | Load data, sampled on acceptance |
| base_wb_valid | output | 1 | Base-register update strobe |
| base_wb_idx | output | 4 | Integer register to update |
| base_wb_data | output | ADDR_W | New base value |
| bank_sel | output | 1 | Physical bank currently in the foreground |
| size_sel | output | 1 | 0: 32-bit moves, 1: 64-bit pair moves |
| dbg_addr | input | 5 | Physical register address, bank in bit 4 |
| dbg_data | output | REG_W | Contents of the addressed physical register |

## Verification
The hardest case to reach is a pair move whose routing depends on three bits at once: the bank-select bit and the low bits of both fields. A background-to-background copy while the banks are swapped writes a physical bank that nothing else touches, so a fault stays hidden unless both banks hold distinct data beforehand. The bench first fills every physical register through 64-bit loads with distinct values. It then sweeps all 256 field combinations in pair mode, with the banks in both orders, and checks the destination pair after each move and the whole file after each sweep. The stalled-response case, where the memory holds `mem_ready` low, is driven by varying the stall length from zero to two cycles over each access form. During the stall the bench checks that the destination register and the base strobe remain untouched.

// File: rtl/fpmov_pkg.sv
package fpmov_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_MOVE,
      K_LOAD,
      K_STORE,
      K_FLIP_BANK,
      K_FLIP_SIZE
   } kind_e;

   typedef enum logic [1:0] {
      AM_IND,
      AM_IDX,
      AM_POST,
      AM_PRE
   } amode_e;

   typedef struct packed {
      kind_e      kind;
      amode_e     amode;
      logic [3:0] fd;
      logic [3:0] fs;
   } dec_t;

   localparam logic [15:0] OPC_FLIP_BANK = 16'hFBFD;
   localparam logic [15:0] OPC_FLIP_SIZE = 16'hF3FD;
   localparam logic [3:0]  OPC_CLASS     = 4'hF;

endpackage

// File: rtl/fpmov_decode.sv
module fpmov_decode
   import fpmov_pkg::*;
(
   input  logic [15:0] op,
   output dec_t        dec
);

   always_comb begin
      dec.kind  = K_NONE;
      dec.amode = AM_IND;
      dec.fd    = op[11:8];
      dec.fs    = op[7:4];
      if (op == OPC_FLIP_BANK) begin
         dec.kind = K_FLIP_BANK;
      end else if (op == OPC_FLIP_SIZE) begin
         dec.kind = K_FLIP_SIZE;
      end else if (op[15:12] == OPC_CLASS) begin
         case (op[3:0])
            4'h6: begin dec.kind = K_LOAD;  dec.amode = AM_IDX;  end
            4'h7: begin dec.kind = K_STORE; dec.amode = AM_IDX;  end
            4'h8: begin dec.kind = K_LOAD;  dec.amode = AM_IND;  end
            4'h9: begin dec.kind = K_LOAD;  dec.amode = AM_POST; end
            4'hA: begin dec.kind = K_STORE; dec.amode = AM_IND;  end
            4'hB: begin dec.kind = K_STORE; dec.amode = AM_PRE;  end
            4'hC: begin dec.kind = K_MOVE;  end
            default: dec.kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/fpmov_agen.sv
module fpmov_agen
   import fpmov_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  amode_e              amode,
   input  logic                wide,
   input  logic [ADDR_W-1:0]   r0,
   input  logic [ADDR_W-1:0]   base,
   output logic [ADDR_W-1:0]   addr,
   output logic [ADDR_W-1:0]   base_new,
   output logic                wb_en
);

   logic [ADDR_W-1:0] step;
   logic [ADDR_W-1:0] dec_base;

   assign step     = wide ? ADDR_W'(8) : ADDR_W'(4);
   assign dec_base = base - step;

   always_comb begin
      addr     = base;
      base_new = base;
      wb_en    = 1'b0;
      case (amode)
         AM_IDX:  addr = base + r0;
         AM_POST: begin
            base_new = base + step;
            wb_en    = 1'b1;
         end
         AM_PRE: begin
            addr     = dec_base;
            base_new = dec_base;
            wb_en    = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/fpmov_regfile.sv
module fpmov_regfile #(
   parameter int REG_W = 32,
   parameter int NREG  = 16
)(
   input  logic                          clk,
   input  logic                          rst,
   input  logic [$clog2(NREG):0]         rd_addr,
   output logic [REG_W-1:0]              rd_hi,
   output logic [REG_W-1:0]              rd_lo,
   input  logic                          we_hi,
   input  logic [$clog2(NREG):0]         wa_hi,
   input  logic [REG_W-1:0]              wd_hi,
   input  logic                          we_lo,
   input  logic [$clog2(NREG):0]         wa_lo,
   input  logic [REG_W-1:0]              wd_lo,
   input  logic [$clog2(NREG):0]         dbg_addr,
   output logic [REG_W-1:0]              dbg_data
);

   localparam int IDX_W = $clog2(NREG);
   localparam int AW    = IDX_W + 1;

   if (NREG < 2 || (NREG % 2) != 0) begin : g_bad_nreg
      $error("fpmov_regfile: NREG must be even and at least 2");
   end

   logic [1:0][REG_W-1:0] bk_hi;
   logic [1:0][REG_W-1:0] bk_lo;
   logic [1:0][REG_W-1:0] bk_dbg;

   logic [IDX_W-1:0] rd_idx_lo;
   assign rd_idx_lo = {rd_addr[IDX_W-1:1], 1'b1};

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [REG_W-1:0] q [NREG];
      logic             hit_hi;
      logic             hit_lo;

      assign hit_hi = we_hi && (wa_hi[AW-1] == 1'(b));
      assign hit_lo = we_lo && (wa_lo[AW-1] == 1'(b));

      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < NREG; i++) q[i] <= '0;
         end else begin
            if (hit_hi) q[wa_hi[IDX_W-1:0]] <= wd_hi;
            if (hit_lo) q[wa_lo[IDX_W-1:0]] <= wd_lo;
         end
      end

      assign bk_hi[b]  = q[rd_addr[IDX_W-1:0]];
      assign bk_lo[b]  = q[rd_idx_lo];
      assign bk_dbg[b] = q[dbg_addr[IDX_W-1:0]];
   end

   assign rd_hi    = bk_hi[rd_addr[AW-1]];
   assign rd_lo    = bk_lo[rd_addr[AW-1]];
   assign dbg_data = bk_dbg[dbg_addr[AW-1]];

   // R3: a pair write lands in one bank on two distinct words
   a_r3_pair_same_bank: assert property (@(posedge clk) disable iff (rst)
      (we_hi && we_lo) |-> (wa_hi != wa_lo) && (wa_hi[AW-1] == wa_lo[AW-1]));

endmodule

// File: rtl/fpmov_unit.sv
module fpmov_unit
   import fpmov_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 32
)(
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  op_valid,
   output logic                  op_ready,
   input  logic [15:0]           op_code,
   input  logic [ADDR_W-1:0]     r0_val,
   input  logic [ADDR_W-1:0]     rm_val,
   input  logic [ADDR_W-1:0]     rn_val,
   output logic                  mem_valid,
   input  logic                  mem_ready,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [2*REG_W-1:0]    mem_wdata,
   input  logic [2*REG_W-1:0]    mem_rdata,
   output logic                  base_wb_valid,
   output logic [3:0]            base_wb_idx,
   output logic [ADDR_W-1:0]     base_wb_data,
   output logic                  bank_sel,
   output logic                  size_sel,
   input  logic [4:0]            dbg_addr,
   output logic [REG_W-1:0]      dbg_data
);

   localparam int IDX_W  = 4;
   localparam int NREG   = 1 << IDX_W;
   localparam int RA_W   = IDX_W + 1;
   localparam int PAIR_W = 2 * REG_W;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("fpmov_unit: ADDR_W must be at least 8");
   end
   if (REG_W < 8) begin : g_bad_reg
      $error("fpmov_unit: REG_W must be at least 8");
   end

   dec_t dec;
   fpmov_decode u_dec (.op(op_code), .dec(dec));

   logic bank_q, size_q, busy_q;
   logic fire, commit;

   assign fire   = op_valid && !busy_q;
   assign commit = busy_q && mem_ready;

   // source and destination physical addresses for the current opcode
   logic            src_bank, dst_bank;
   logic [IDX_W-1:0] src_idx, dst_idx;

   assign src_bank = size_q ? (bank_q ^ dec.fs[0]) : bank_q;
   assign dst_bank = size_q ? (bank_q ^ dec.fd[0]) : bank_q;
   assign src_idx  = size_q ? {dec.fs[IDX_W-1:1], 1'b0} : dec.fs;
   assign dst_idx  = size_q ? {dec.fd[IDX_W-1:1], 1'b0} : dec.fd;

   // address generation
   logic [ADDR_W-1:0] ag_base, ag_addr, ag_new;
   logic              ag_wb;

   assign ag_base = (dec.kind == K_LOAD) ? rm_val : rn_val;

   fpmov_agen #(.ADDR_W(ADDR_W)) u_agen (
      .amode    (dec.amode),
      .wide     (size_q),
      .r0       (r0_val),
      .base     (ag_base),
      .addr     (ag_addr),
      .base_new (ag_new),
      .wb_en    (ag_wb)
   );

   // register file
   logic [REG_W-1:0] rd_hi, rd_lo;
   logic             we_hi, we_lo;
   logic [RA_W-1:0]  wa_hi, wa_lo;
   logic [REG_W-1:0] wd_hi, wd_lo;

   fpmov_regfile #(.REG_W(REG_W), .NREG(NREG)) u_rf (
      .clk      (clk),
      .rst      (rst),
      .rd_addr  ({src_bank, src_idx}),
      .rd_hi    (rd_hi),
      .rd_lo    (rd_lo),
      .we_hi    (we_hi),
      .wa_hi    (wa_hi),
      .wd_hi    (wd_hi),
      .we_lo    (we_lo),
      .wa_lo    (wa_lo),
      .wd_lo    (wd_lo),
      .dbg_addr (dbg_addr),
      .dbg_data (dbg_data)
   );

   // pending access, captured at issue
   logic [ADDR_W-1:0] p_addr, p_base_new;
   logic [PAIR_W-1:0] p_wdata;
   logic              p_we, p_wide, p_wb;
   logic [RA_W-1:0]   p_dst;
   logic [3:0]        p_base_idx;
   logic              is_mem;

   assign is_mem = (dec.kind == K_LOAD) || (dec.kind == K_STORE);

   always_ff @(posedge clk) begin
      if (rst) begin
         bank_q     <= 1'b0;
         size_q     <= 1'b0;
         busy_q     <= 1'b0;
         p_addr     <= '0;
         p_base_new <= '0;
         p_wdata    <= '0;
         p_we       <= 1'b0;
         p_wide     <= 1'b0;
         p_wb       <= 1'b0;
         p_dst      <= '0;
         p_base_idx <= '0;
      end else begin
         if (commit) busy_q <= 1'b0;
         if (fire) begin
            if (dec.kind == K_FLIP_BANK) bank_q <= ~bank_q;
            if (dec.kind == K_FLIP_SIZE) size_q <= ~size_q;
            if (is_mem) begin
               busy_q     <= 1'b1;
               p_addr     <= ag_addr;
               p_base_new <= ag_new;
               p_wb       <= ag_wb;
               p_we       <= (dec.kind == K_STORE);
               p_wide     <= size_q;
               p_dst      <= {dst_bank, dst_idx};
               p_base_idx <= (dec.kind == K_LOAD) ? dec.fs : dec.fd;
               p_wdata    <= size_q ? {rd_hi, rd_lo} : {{REG_W{1'b0}}, rd_hi};
            end
         end
      end
   end

   // write port steering: load commit or same-cycle move
   always_comb begin
      we_hi = 1'b0;
      we_lo = 1'b0;
      wa_hi = {dst_bank, dst_idx};
      wa_lo = {dst_bank, dst_idx[IDX_W-1:1], 1'b1};
      wd_hi = rd_hi;
      wd_lo = rd_lo;
      if (commit && !p_we) begin
         we_hi = 1'b1;
         we_lo = p_wide;
         wa_hi = p_dst;
         wa_lo = {p_dst[RA_W-1:1], 1'b1};
         wd_hi = p_wide ? mem_rdata[PAIR_W-1:REG_W] : mem_rdata[REG_W-1:0];
         wd_lo = mem_rdata[REG_W-1:0];
      end else if (fire && dec.kind == K_MOVE) begin
         we_hi = 1'b1;
         we_lo = size_q;
      end
   end

   assign op_ready      = !busy_q;
   assign mem_valid     = busy_q;
   assign mem_we        = p_we;
   assign mem_addr      = p_addr;
   assign mem_wdata     = p_wdata;
   assign base_wb_valid = commit && p_wb;
   assign base_wb_idx   = p_base_idx;
   assign base_wb_data  = p_base_new;
   assign bank_sel      = bank_q;
   assign size_sel      = size_q;

   // R1: reset leaves modes clear and no request
   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !mem_valid && !bank_sel && !size_sel);

   // R4: bank toggle inverts the bank select
   a_r4_bank_flip: assert property (@(posedge clk) disable iff (rst)
      (fire && dec.kind == K_FLIP_BANK) |=> (bank_sel != $past(bank_sel)) && $stable(size_sel));

   // R5: size toggle inverts the size bit only
   a_r5_size_flip: assert property (@(posedge clk) disable iff (rst)
      (fire && dec.kind == K_FLIP_SIZE) |=> (size_sel != $past(size_sel)) && $stable(bank_sel));

   // R7: pre-decrement store updates the base to the access address
   a_r7_predec_base: assert property (@(posedge clk) disable iff (rst)
      (base_wb_valid && mem_we) |-> base_wb_data == mem_addr);

   // R7: post-increment load advances the base by one step
   a_r7_postinc_step: assert property (@(posedge clk) disable iff (rst)
      (base_wb_valid && !mem_we) |->
         (base_wb_data - mem_addr) == (size_sel ? ADDR_W'(8) : ADDR_W'(4)));

   // R9: request held steady until accepted
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && !mem_ready) |=>
         mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

   // R9: base strobe only on acceptance
   a_r9_wb_on_accept: assert property (@(posedge clk) disable iff (rst)
      base_wb_valid |-> mem_valid && mem_ready);

   // R9: no new opcode while a request is outstanding
   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
      mem_valid |-> !op_ready);

endmodule

// File: tb/fpmov_unit_test.sv
`timescale 1ns/1ps
module fpmov_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [15:0] op_code = 16'h0;
   logic [31:0] r0_val = '0, rm_val = '0, rn_val = '0;
   logic        mem_valid, mem_ready = 1'b0, mem_we;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata, mem_rdata = '0;
   logic        base_wb_valid;
   logic [3:0]  base_wb_idx;
   logic [31:0] base_wb_data;
   logic        bank_sel, size_sel;
   logic [4:0]  dbg_addr = '0;
   logic [31:0] dbg_data;

   fpmov_unit uut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
      .r0_val(r0_val), .rm_val(rm_val), .rn_val(rn_val),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .base_wb_valid(base_wb_valid), .base_wb_idx(base_wb_idx), .base_wb_data(base_wb_data),
      .bank_sel(bank_sel), .size_sel(size_sel), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   logic [31:0] em [2][16];
   logic eb = 1'b0, es = 1'b0;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      finish_run();
   end

   task automatic check_regs(string req);
      for (int a = 0; a < 32; a++) begin
         dbg_addr = 5'(a);
         #0.1;
         chk(req, {32'h0, dbg_data}, {32'h0, em[a / 16][a % 16]});
      end
   endtask

   task automatic check_modes(string req);
      chk(req, {62'h0, bank_sel, size_sel}, {62'h0, eb, es});
   endtask

   task automatic issue(logic [15:0] op);
      op_code  = op;
      op_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic flip_bank();
      issue(16'hFBFD);
      eb = ~eb;
      check_modes("R4 bank toggle");
   endtask

   task automatic flip_size();
      issue(16'hF3FD);
      es = ~es;
      check_modes("R5 size toggle");
   endtask

   task automatic mem_op(logic [15:0] op, logic [31:0] r0, logic [31:0] rm, logic [31:0] rn,
                         logic [63:0] rdata, int stall);
      logic [3:0]  nib, n, m;
      logic        ld, wb, db, sb;
      logic [31:0] base, ea, nb, step;
      logic [63:0] wexp;
      logic [3:0]  pd, ps;
      nib  = op[3:0];
      n    = op[11:8];
      m    = op[7:4];
      ld   = (nib == 4'h6) || (nib == 4'h8) || (nib == 4'h9);
      step = es ? 32'd8 : 32'd4;
      base = ld ? rm : rn;
      ea   = base;
      nb   = base;
      wb   = 1'b0;
      if (nib == 4'h6 || nib == 4'h7) ea = base + r0;
      if (nib == 4'h9) begin nb = base + step; wb = 1'b1; end
      if (nib == 4'hB) begin nb = base - step; ea = nb; wb = 1'b1; end
      sb = eb ^ m[0];
      ps = {m[3:1], 1'b0};
      db = eb ^ n[0];
      pd = {n[3:1], 1'b0};
      wexp = es ? {em[sb][ps], em[sb][ps | 4'h1]} : {32'h0, em[eb][m]};
      r0_val = r0;
      rm_val = rm;
      rn_val = rn;
      issue(op);
      chk("R9 request raised", {62'h0, mem_valid, op_ready}, {62'h0, 2'b10});
      chk("R6 address", {32'h0, mem_addr}, {32'h0, ea});
      chk("R6 direction", {63'h0, mem_we}, {63'h0, ~ld});
      if (!ld) chk("R8 store data layout", mem_wdata, wexp);
      for (int s = 0; s < stall; s++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R9 held during stall", {mem_valid, base_wb_valid, mem_addr}, {1'b1, 1'b0, ea});
         if (ld) begin
            dbg_addr = es ? {db, pd} : {eb, n};
            #0.1;
            chk("R9 no early load write", {32'h0, dbg_data},
                {32'h0, es ? em[db][pd] : em[eb][n]});
         end
      end
      mem_ready = 1'b1;
      mem_rdata = rdata;
      #1;
      chk("R7 strobe", {63'h0, base_wb_valid}, {63'h0, wb});
      if (wb) chk("R7 new base and index", {28'h0, base_wb_idx, base_wb_data},
                  {28'h0, ld ? m : n, nb});
      @(posedge clk);
      @(negedge clk);
      mem_ready = 1'b0;
      chk("R9 request retired", {62'h0, mem_valid, op_ready}, {62'h0, 2'b01});
      if (ld) begin
         if (es) begin
            em[db][pd]        = rdata[63:32];
            em[db][pd | 4'h1] = rdata[31:0];
         end else begin
            em[eb][n] = rdata[31:0];
         end
      end
   endtask

   // fills all 32 physical registers through 64-bit loads
   task automatic reload(int seed);
      logic was32;
      was32 = !es;
      if (was32) flip_size();
      for (int i = 0; i < 16; i++) begin
         mem_op({4'hF, 4'(i), 4'h3, 4'h8}, 32'h0, 32'h2000_0000 + 32'(i * 8), 32'h0,
                {32'(seed * 1000 + i * 37 + 1), 32'(seed * 777 + i * 91 + 5)}, 0);
      end
      if (was32) flip_size();
   endtask

   task automatic do_move(logic [3:0] n, logic [3:0] m);
      logic [31:0] hi, lo;
      logic sb, db;
      logic [3:0] ps, pd;
      issue({4'hF, n, m, 4'hC});
      if (!es) begin
         em[eb][n] = em[eb][m];
         dbg_addr = {eb, n};
         #0.1;
         chk("R2 single move", {32'h0, dbg_data}, {32'h0, em[eb][n]});
      end else begin
         sb = eb ^ m[0]; db = eb ^ n[0];
         ps = {m[3:1], 1'b0}; pd = {n[3:1], 1'b0};
         hi = em[sb][ps]; lo = em[sb][ps | 4'h1];
         em[db][pd] = hi; em[db][pd | 4'h1] = lo;
         dbg_addr = {db, pd};
         #0.1;
         chk("R3 pair move even", {32'h0, dbg_data}, {32'h0, hi});
         dbg_addr = {db, pd | 4'h1};
         #0.1;
         chk("R3 pair move odd", {32'h0, dbg_data}, {32'h0, lo});
      end
   endtask

   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 16; i++) em[b][i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1
      check_regs("R1 reset registers");
      check_modes("R1 reset modes");
      chk("R1 idle", {62'h0, mem_valid, op_ready}, {62'h0, 2'b01});

      // 32-bit loads into each bank
      for (int i = 0; i < 16; i++)
         mem_op({4'hF, 4'(i), 4'h1, 4'h8}, 0, 32'h1000_0000 + 32'(i * 4), 0,
                {32'hFFFF_0000, 32'h0100_0000 + 32'(i * 32'h0101)}, i % 3);
      check_regs("R6 single loads bank");
      flip_bank();
      for (int i = 0; i < 16; i++)
         mem_op({4'hF, 4'(i), 4'h2, 4'h8}, 0, 32'h1100_0000 + 32'(i * 4), 0,
                {32'hEEEE_0000, 32'h0200_0000 + 32'(i * 32'h0307)}, 0);
      check_regs("R4 background bank filled while swapped");
      flip_bank();

      // R2 sweep
      for (int n = 0; n < 16; n++)
         for (int m = 0; m < 16; m++) do_move(4'(n), 4'(m));
      check_regs("R2 file after single sweep");

      // R3 sweeps, both bank orders
      flip_size();
      for (int pass = 0; pass < 2; pass++) begin
         reload(pass + 1);
         for (int n = 0; n < 16; n++)
            for (int m = 0; m < 16; m++) do_move(4'(n), 4'(m));
         check_regs("R3 file after pair sweep");
         flip_bank();
      end
      flip_size();

      // addressing sweep, both sizes
      for (int sz = 0; sz < 2; sz++) begin
         reload(sz + 7);
         for (int k = 0; k < 6; k++) begin
            logic [3:0] nib;
            case (k)
               0: nib = 4'h6; 1: nib = 4'h7; 2: nib = 4'h8;
               3: nib = 4'h9; 4: nib = 4'hA; default: nib = 4'hB;
            endcase
            for (int i = 0; i < 16; i++)
               mem_op({4'hF, 4'(i), 4'((i * 5 + 3) & 15), nib},
                      32'h0000_0100 + 32'(i * 8), 32'h3000_0000 + 32'(i * 64),
                      32'h4000_0000 + 32'(i * 128),
                      {32'hA000_0000 + 32'(i * 17 + k), 32'h5000_0000 + 32'(i * 29 + sz)}, i % 3);
         end
         check_regs("R6 file after access sweep");
         flip_size();
      end

      // R10 opcodes without effect
      for (int k = 0; k < 5; k++) begin
         logic [15:0] op;
         case (k)
            0: op = 16'hE12C; 1: op = 16'hF12D; 2: op = 16'hF000;
            3: op = 16'hF5FD; default: op = 16'hF00F;
         endcase
         issue(op);
         chk("R10 no request", {62'h0, mem_valid, op_ready}, {62'h0, 2'b01});
         check_modes("R10 modes unchanged");
         check_regs("R10 registers unchanged");
      end

      finish_run();
   end

endmodule